// File: doc/BRIEF.md
# Tagged Two-Bit Branch Direction Predictor

This block guesses the direction of a branch during instruction fetch. It is a direct-mapped table. The fetch address selects one entry, and the rest of that address is compared with the tag stored in the entry. When the tags match and the entry is valid, the block reports a hit. The predicted direction then comes from the entry's two-bit saturating counter. When the lookup misses, no prediction is made and the fetch unit carries on sequentially. Instructions that are not branches are never written into the table, so they always miss.

When a branch resolves, the pipeline presents the branch address and the actual outcome on the resolve port. If the addressed entry already holds that branch, its counter steps toward the outcome. Otherwise the entry is taken over: the new tag is written and the counter starts in the weak state that matches the outcome. Because the counter has two bits of hysteresis, one surprise does not reverse a strongly held prediction. A loop exit therefore costs one misprediction per pass instead of two.

The lookup is combinational from the stored state. A resolve takes effect at the clock edge, so a lookup of the same entry in the same cycle still sees the old contents.

Top module: `bpb_predictor`

## Requirements
- R1: After reset every lookup misses (`lk_hit_o`=0, `lk_taken_o`=0) until a resolve installs an entry.
- R2: On a miss `lk_taken_o` is 0.
- R3: After a resolve of address A, a lookup of A in any later cycle hits, provided no other resolve has since written the same entry.
- R4: A resolve that allocates an entry sets its counter to 2 (weakly taken) when the outcome is taken, and to 1 (weakly not-taken) otherwise.
- R5: The prediction is taken when the counter is 2 or 3. A resolve to a matching entry adds 1 for taken and subtracts 1 for not-taken, saturating at 3 and at 0. Two consecutive opposite outcomes are needed to flip a saturated entry.
- R6: An address that shares an entry's index but has a different tag misses.
- R7: A resolve whose tag differs from the stored tag replaces that entry and reinitialises its counter as in R4. The old address then misses.
- R8: A lookup in the same cycle as a resolve of the same entry returns the contents from before that resolve.
- R9: Index bits are address bits [OFS+IDX_W-1:OFS], with OFS=2 and IDX_W=log2(DEPTH). The tag is all the bits above the index. Address bits below OFS have no effect on lookup or resolve.
- R10: A branch run twice as a 10-iteration loop (nine taken outcomes, then one not-taken) is mispredicted exactly once on the second run. A miss counts as a not-taken prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid bits |
| lk_addr_i | input | ADDR_W | Fetch address to look up |
| lk_hit_o | output | 1 | Valid entry with matching tag |
| lk_taken_o | output | 1 | Predicted taken (only when hit) |
| rs_valid_i | input | 1 | A branch resolves this cycle |
| rs_addr_i | input | ADDR_W | Address of the resolving branch |
| rs_taken_i | input | 1 | Actual outcome of the resolving branch |

## Verification
Corruption inside the table shows at the ports in three ways:
- A wrong tag or valid bit appears as a hit or miss flag that differs from the reference model, on the very next lookup of that index.
- A counter error surfaces on a direction flip. It may only become visible after one or two further resolves, when the bench expects a flip that does not occur or sees one too early.
- Same-cycle read and write ordering and index and tag slicing are observed directly through lookups of aliasing addresses and addresses with different low bits.

The bench models the table behaviourally and compares both outputs on every cycle.

// File: rtl/bpb_pkg.sv
package bpb_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MIN     = 2'd0;
  localparam ctr_t CTR_WEAK_NT = 2'd1;
  localparam ctr_t CTR_WEAK_T  = 2'd2;
  localparam ctr_t CTR_MAX     = 2'd3;

  function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
    ctr_t r;
    if (up) r = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else    r = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return r;
  endfunction
endpackage

// File: rtl/bpb_addr_split.sv
module bpb_addr_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 12,
  parameter int OFS    = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFS
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic unused_low_bits;

  assign idx_o           = addr_i[OFS +: IDX_W];
  assign tag_o           = addr_i[ADDR_W-1 -: TAG_W];
  assign unused_low_bits = ^addr_i[OFS-1:0];
endmodule

// File: rtl/bpb_ctr_update.sv
module bpb_ctr_update
  import bpb_pkg::*;
(
  input  logic match_i,
  input  logic taken_i,
  input  ctr_t cur_i,
  output ctr_t nxt_o
);
  always_comb begin
    if (match_i) nxt_o = ctr_step(cur_i, taken_i);
    else         nxt_o = taken_i ? CTR_WEAK_T : CTR_WEAK_NT;
  end
endmodule

// File: rtl/bpb_store.sv
module bpb_store
  import bpb_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int TAG_W = 18,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx_i,
  output logic             a_valid_o,
  output logic [TAG_W-1:0] a_tag_o,
  output ctr_t             a_ctr_o,
  input  logic [IDX_W-1:0] b_idx_i,
  output logic             b_valid_o,
  output logic [TAG_W-1:0] b_tag_o,
  output ctr_t             b_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  ctr_t             wr_ctr_i
);
  logic [DEPTH-1:0] valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [DEPTH];
  ctr_t             ctr_q [DEPTH];

  always_comb begin
    valid_d = valid_q;
    if (wr_en_i) valid_d[wr_idx_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i] <= wr_tag_i;
      ctr_q[wr_idx_i] <= wr_ctr_i;
    end
  end

  assign a_valid_o = valid_q[a_idx_i];
  assign a_tag_o   = tag_q[a_idx_i];
  assign a_ctr_o   = ctr_q[a_idx_i];
  assign b_valid_o = valid_q[b_idx_i];
  assign b_tag_o   = tag_q[b_idx_i];
  assign b_ctr_o   = ctr_q[b_idx_i];
endmodule

// File: rtl/bpb_predictor.sv
module bpb_predictor
  import bpb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4096,
  parameter int OFS    = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TAG_W = ADDR_W - IDX_W - OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic              lk_taken_o,
  input  logic              rs_valid_i,
  input  logic [ADDR_W-1:0] rs_addr_i,
  input  logic              rs_taken_i
);
  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic [TAG_W-1:0] lk_tag, rs_tag, a_tag, b_tag;
  logic             a_valid, b_valid, rs_match;
  ctr_t             a_ctr, b_ctr, wr_ctr;

  bpb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS(OFS)) lk_split_i (
    .addr_i(lk_addr_i), .idx_o(lk_idx), .tag_o(lk_tag));

  bpb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS(OFS)) rs_split_i (
    .addr_i(rs_addr_i), .idx_o(rs_idx), .tag_o(rs_tag));

  bpb_store #(.DEPTH(DEPTH), .TAG_W(TAG_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .a_idx_i(lk_idx), .a_valid_o(a_valid), .a_tag_o(a_tag), .a_ctr_o(a_ctr),
    .b_idx_i(rs_idx), .b_valid_o(b_valid), .b_tag_o(b_tag), .b_ctr_o(b_ctr),
    .wr_en_i(rs_valid_i), .wr_idx_i(rs_idx), .wr_tag_i(rs_tag), .wr_ctr_i(wr_ctr));

  assign rs_match = b_valid && (b_tag == rs_tag);

  bpb_ctr_update ctr_upd_i (
    .match_i(rs_match), .taken_i(rs_taken_i), .cur_i(b_ctr), .nxt_o(wr_ctr));

  assign lk_hit_o   = a_valid && (a_tag == lk_tag);
  assign lk_taken_o = lk_hit_o && a_ctr[1];
endmodule

// File: rtl/bpb_predictor_chk.sv
module bpb_predictor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] lk_addr_i,
  input logic              lk_hit_o,
  input logic              lk_taken_o,
  input logic              rs_valid_i,
  input logic [ADDR_W-1:0] rs_addr_i,
  input logic              rs_taken_i
);
  // R2
  miss_never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit_o |-> !lk_taken_o);

  // R3
  install_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid_i |=> ((lk_addr_i != $past(rs_addr_i)) || rs_valid_i || lk_hit_o));

  // R4
  alloc_weak_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid_i && rs_taken_i && (lk_addr_i == rs_addr_i) && !lk_hit_o)
    |=> ((lk_addr_i != $past(rs_addr_i)) || rs_valid_i || lk_taken_o));

  // R4
  alloc_weak_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid_i && !rs_taken_i && (lk_addr_i == rs_addr_i) && !lk_hit_o)
    |=> ((lk_addr_i != $past(rs_addr_i)) || rs_valid_i || (lk_hit_o && !lk_taken_o)));

  // R8
  same_cycle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rs_valid_i && $past(!rs_valid_i) && $stable(lk_addr_i)) |-> $stable(lk_hit_o));
endmodule

bind bpb_predictor bpb_predictor_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_addr_i(lk_addr_i), .lk_hit_o(lk_hit_o),
  .lk_taken_o(lk_taken_o), .rs_valid_i(rs_valid_i), .rs_addr_i(rs_addr_i),
  .rs_taken_i(rs_taken_i));

// File: tb/bpb_predictor_tb_top.sv
`timescale 1ns/1ps
module bpb_predictor_tb_top;
  localparam int ADDR_W = 32;
  localparam int DEPTH  = 4096;
  localparam int IDX_W  = 12;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] lk_addr;
  logic              lk_hit, lk_taken;
  logic              rs_valid;
  logic [ADDR_W-1:0] rs_addr;
  logic              rs_taken;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  bit m_valid [DEPTH];
  int m_tag   [DEPTH];
  int m_ctr   [DEPTH];

  bpb_predictor #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_addr_i(lk_addr), .lk_hit_o(lk_hit),
    .lk_taken_o(lk_taken), .rs_valid_i(rs_valid), .rs_addr_i(rs_addr),
    .rs_taken_i(rs_taken));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int idx_of(input logic [ADDR_W-1:0] a);
    return int'((a >> 2) % DEPTH);
  endfunction

  function automatic int tag_of(input logic [ADDR_W-1:0] a);
    return int'(a >> (2 + IDX_W));
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // One cycle: drive, compare the model's prediction, then advance the model at the edge.
  task automatic step(input logic [ADDR_W-1:0] la, input bit rv,
                      input logic [ADDR_W-1:0] ra, input bit rt,
                      input string req, output bit pred);
    int li, ri;
    bit eh, et;
    @(negedge clk);
    lk_addr = la; rs_valid = rv; rs_addr = ra; rs_taken = rt;
    #1;
    li = idx_of(la);
    eh = m_valid[li] && (m_tag[li] == tag_of(la));
    et = eh && (m_ctr[li] >= 2);
    check(req, "hit", int'(lk_hit), int'(eh));
    check(req, "taken", int'(lk_taken), int'(et));
    pred = lk_taken;
    @(posedge clk);
    if (rv) begin
      ri = idx_of(ra);
      if (m_valid[ri] && m_tag[ri] == tag_of(ra)) begin
        if (rt) m_ctr[ri] = (m_ctr[ri] == 3) ? 3 : m_ctr[ri] + 1;
        else    m_ctr[ri] = (m_ctr[ri] == 0) ? 0 : m_ctr[ri] - 1;
      end else begin
        m_valid[ri] = 1'b1;
        m_tag[ri]   = tag_of(ra);
        m_ctr[ri]   = rt ? 2 : 1;
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [ADDR_W-1:0] b, alias_b, c;
    bit p;
    int miss2;
    b       = 32'h0000_1000;
    alias_b = b + 32'h0000_4000;
    c       = 32'h0002_0040;
    for (int i = 0; i < DEPTH; i++) begin
      m_valid[i] = 0; m_tag[i] = 0; m_ctr[i] = 0;
    end
    lk_addr = '0; rs_valid = 0; rs_addr = '0; rs_taken = 0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty table after reset
    step(b, 0, '0, 0, "R1", p);
    step(32'hDEAD_BEEC, 0, '0, 0, "R1", p);
    step(c, 0, '0, 0, "R1", p);
    // R3 / R4: install taken, then hit weakly taken
    step(c, 1, b, 1, "R3", p);
    step(b, 0, '0, 0, "R4", p);
    // R4: one not-taken flips the weak entry
    step(b, 1, b, 0, "R4", p);
    step(b, 0, '0, 0, "R4", p);
    // R5: saturate at 3, then two not-taken needed
    step(b, 1, b, 1, "R5", p);
    step(b, 1, b, 1, "R5", p);
    step(b, 1, b, 1, "R5", p);
    step(b, 1, b, 1, "R5", p);
    step(b, 1, b, 0, "R5", p);
    step(b, 1, b, 0, "R5", p);
    step(b, 1, b, 0, "R5", p);
    step(b, 1, b, 0, "R5", p);
    step(b, 1, b, 0, "R5", p);
    step(b, 1, b, 1, "R5", p);
    step(b, 0, '0, 0, "R5", p);
    // R6: aliasing address misses
    step(alias_b, 0, '0, 0, "R6", p);
    // R7: replacement
    step(alias_b, 1, alias_b, 0, "R7", p);
    step(b, 0, '0, 0, "R7", p);
    step(alias_b, 0, '0, 0, "R7", p);
    // R8: same-cycle lookup sees old contents
    step(alias_b, 1, alias_b, 1, "R8", p);
    step(alias_b, 0, '0, 0, "R8", p);
    // R9: low address bits ignored on both ports
    step(alias_b + 32'd3, 0, '0, 0, "R9", p);
    step(b, 1, b + 32'd1, 1, "R9", p);
    step(b + 32'd2, 0, '0, 0, "R9", p);
    // R2: miss while another entry is live
    step(32'h0000_2000, 0, '0, 0, "R2", p);

    // R10: 10-iteration loop, run twice
    for (int run = 0; run < 2; run++) begin
      miss2 = 0;
      for (int it = 0; it < 10; it++) begin
        bit outcome;
        outcome = (it != 9);
        step(c, 1, c, outcome, "R10", p);
        if (p != outcome) miss2++;
      end
    end
    check("R10", "second-run mispredictions", miss2, 1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule